// File: doc/BRIEF.md
# Serial Flash Block-Erase Command Front End

This block is the device side of a serial flash command port, limited to the block-erase path. It oversamples the serial clock, chip select and data input with its own system clock, shifts in an opcode and a 24-bit address in SPI mode 0 (data captured on the rising serial clock edge, most significant bit first), and checks a write-enable latch. When chip select is released after a complete, qualified erase command, it starts a self-timed erase. The erase covers a 4 KB, 32 KB or 64 KB region, chosen by the opcode.

While an erase runs, a status byte stays readable over the same port and shows a busy flag and the latch. The storage is a small behavioural array with one byte for each 4 KB sector and a combinational probe port for inspection. The erase duration is a parameter counted in system clock cycles.

Top module: `sflash_erase_ctrl`

## Requirements
- R1: After reset the status byte is 00h, `miso` is 0, and sector i of the array holds (i XOR 5Ah) truncated to 8 bits.
- R2: A transfer whose first byte is 06h sets the write-enable latch when chip select is released, provided the block is not busy at the clock where the release is processed.
- R3: After a first byte of 05h, `miso` returns the status byte MSB first, one bit per falling serial clock edge, and repeats it for every further byte. Bit 0 is busy, bit 1 is the write-enable latch, and bits 7..2 are 0. Each byte is a snapshot taken at the start of that byte.
- R4: A first byte of 20h, 52h or D8h, followed by exactly three address bytes and accepted with the latch set, makes busy go high and clears the latch in the same clock as chip select release is processed.
- R5: At completion, every sector of the addressed block reads FFh and all other sectors are unchanged. The block base is the address with its low 12 bits (opcode 20h), 15 bits (52h) or 16 bits (D8h) cleared. Sector index = base bits [23:12] modulo the sector count.
- R6: An erase command received while the write-enable latch is clear does nothing: busy stays low and the array is unchanged.
- R7: If chip select is released before 32 bits have arrived, an erase command is dropped and the latch keeps its value.
- R8: Bits clocked in after the three address bytes do not alter the captured address.
- R9: Busy stays high for exactly ERASE_CYCLES clock cycles. The array changes in the clock where busy falls.
- R10: While busy, every opcode other than 05h is ignored at release, and the latch stays 0. A release processed in the very clock that ends the erase is still ignored.
- R11: Any other opcode has no effect on the latch, busy or the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block (status reads) |
| probe_sel | input | $clog2(NUM_SEC) | Sector index to inspect |
| probe_data | output | 8 | Contents of the selected sector |

## Verification
Two things can land on the same clock edge: the decision on a newly released command, and the last cycle of a running erase. The bench holds a Write Enable transfer open with chip select low. It releases chip select exactly when its own model says the release will be processed in the completion cycle, and then repeats the test one cycle later. A status read afterwards judges the outcome: the latch must read 0 in the first case and 1 in the second. Throughout, the probe port is compared against the model on every clock, so the cycle in which the erased sectors turn to FFh is pinned to the clock where busy ends.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int unsigned SEC_LSB = 12;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_RDST  = 8'h05;
  localparam logic [7:0] OPC_ER4K  = 8'h20;
  localparam logic [7:0] OPC_ER32K = 8'h52;
  localparam logic [7:0] OPC_ER64K = 8'hD8;

  typedef enum logic [1:0] {BLK_4K = 2'd0, BLK_32K = 2'd1, BLK_64K = 2'd2} blk_e;

  function automatic logic is_erase(input logic [7:0] op);
    return op inside {OPC_ER4K, OPC_ER32K, OPC_ER64K};
  endfunction

  function automatic blk_e op_to_blk(input logic [7:0] op);
    case (op)
      OPC_ER32K: return BLK_32K;
      OPC_ER64K: return BLK_64K;
      default:   return BLK_4K;
    endcase
  endfunction

  // log2 of the number of 4 KB sectors in a block
  function automatic logic [4:0] blk_lg(input blk_e b);
    case (b)
      BLK_32K: return 5'd3;
      BLK_64K: return 5'd4;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [23:0] blk_base(input logic [23:0] a, input blk_e b);
    case (b)
      BLK_32K: return {a[23:15], 15'd0};
      BLK_64K: return {a[23:16], 16'd0};
      default: return {a[23:12], 12'd0};
    endcase
  endfunction

  function automatic logic [11:0] base_sector(input logic [23:0] a, input blk_e b);
    logic [23:0] t;
    t = blk_base(a, b);
    return t[23:SEC_LSB];
  endfunction

  function automatic logic [7:0] sec_seed(input int unsigned i);
    return 8'(i) ^ 8'h5A;
  endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_release,
  output logic mosi_s
);
  // lane order: [2] sck, [1] cs_n, [0] mosi
  logic [2:0] stg [STAGES];
  logic       sck_d, cs_d;

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= 3'b010;
    else        stg[0] <= {sck, cs_n, mosi};
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[k] <= 3'b010;
      else        stg[k] <= stg[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= stg[STAGES-1][2];
      cs_d  <= stg[STAGES-1][1];
    end
  end

  assign sck_rise   =  stg[STAGES-1][2] & ~sck_d;
  assign sck_fall   = ~stg[STAGES-1][2] &  sck_d;
  assign cs_act     = ~stg[STAGES-1][1];
  assign cs_release =  stg[STAGES-1][1] & ~cs_d;
  assign mosi_s     =  stg[STAGES-1][0];
endmodule

// File: rtl/sfe_rx.sv
module sfe_rx
  import sfe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_rise,
  input  logic        sck_fall,
  input  logic        cs_act,
  input  logic        mosi_s,
  input  logic [7:0]  status,
  output logic [7:0]  opcode,
  output logic [23:0] addr,
  output logic [5:0]  nbits,
  output logic        miso
);
  localparam logic [5:0] FULL = 6'd32;

  logic [2:0] ob;
  logic [7:0] tx_q;
  logic       rd_active;

  assign rd_active = (nbits >= 6'd8) && (opcode == OPC_RDST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opcode <= '0;
      addr   <= '0;
      nbits  <= '0;
      ob     <= '0;
      tx_q   <= '0;
      miso   <= 1'b0;
    end else if (!cs_act) begin
      nbits <= '0;
      ob    <= '0;
      miso  <= 1'b0;
    end else begin
      if (sck_rise && nbits != FULL) begin
        if (nbits < 6'd8) opcode <= {opcode[6:0], mosi_s};
        else              addr   <= {addr[22:0], mosi_s};
        nbits <= nbits + 6'd1;
      end
      if (sck_fall && rd_active) begin
        if (ob == 3'd0) begin
          miso <= status[7];
          tx_q <= {status[6:0], 1'b0};
        end else begin
          miso <= tx_q[7];
          tx_q <= {tx_q[6:0], 1'b0};
        end
        ob <= ob + 3'd1;
      end
    end
  end

  // R3
  miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(sck_fall) || $past(!cs_act)));

  // R8
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nbits == FULL) |=> $stable(addr));
endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
  import sfe_pkg::*;
#(
  parameter int NUM_SEC      = 64,
  parameter int ERASE_CYCLES = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_release,
  input  logic [7:0]  opcode,
  input  logic [23:0] addr,
  input  logic [5:0]  nbits,
  output logic        busy,
  output logic        wel,
  output logic        erase_go,
  output logic [$clog2(NUM_SEC)-1:0] erase_sec,
  output blk_e        erase_blk
);
  localparam int SEC_W = $clog2(NUM_SEC);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic             cmd_wren, launch;

  assign cmd_wren = cs_release && !busy && opcode == OPC_WREN && nbits >= 6'd8;
  assign launch   = cs_release && !busy && is_erase(opcode) && nbits == 6'd32 && wel;
  assign erase_go = busy && cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wel       <= 1'b0;
      cnt       <= '0;
      erase_sec <= '0;
      erase_blk <= BLK_4K;
    end else begin
      if (erase_go)  busy <= 1'b0;
      else if (busy) cnt  <= cnt - 1'b1;
      if (cmd_wren)  wel  <= 1'b1;
      if (launch) begin
        busy      <= 1'b1;
        wel       <= 1'b0;
        cnt       <= CNT_W'(ERASE_CYCLES - 1);
        erase_sec <= SEC_W'(base_sector(addr, op_to_blk(opcode)));
        erase_blk <= op_to_blk(opcode);
      end
    end
  end

  // checker-only: length of the current busy window
  logic [CNT_W-1:0] chk_len;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) chk_len <= '0;
    else                 chk_len <= chk_len + 1'b1;
  end

  // R4
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && !wel));

  // R2
  wel_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> ($past(cs_release) && !$past(busy)));

  // R9
  erase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_len == CNT_W'(ERASE_CYCLES)));

  // R10
  busy_wel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wel);
endmodule

// File: rtl/sfe_array.sv
module sfe_array
  import sfe_pkg::*;
#(
  parameter int NUM_SEC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       erase_go,
  input  logic [$clog2(NUM_SEC)-1:0] erase_sec,
  input  blk_e       erase_blk,
  input  logic [$clog2(NUM_SEC)-1:0] probe_sel,
  output logic [7:0] probe_data
);
  localparam int SEC_W = $clog2(NUM_SEC);

  logic [7:0] mem [NUM_SEC];
  logic [4:0] lg;

  assign lg = blk_lg(erase_blk);

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= sec_seed(g);
      else if (erase_go && (((SEC_W'(g) ^ erase_sec) >> lg) == '0))
        mem[g] <= 8'hFF;
    end
  end

  assign probe_data = mem[probe_sel];

  // R5
  erased_base_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (mem[erase_sec] == 8'hFF));
endmodule

// File: rtl/sflash_erase_ctrl.sv
module sflash_erase_ctrl
  import sfe_pkg::*;
#(
  parameter int NUM_SEC      = 64,
  parameter int ERASE_CYCLES = 2000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  input  logic [$clog2(NUM_SEC)-1:0] probe_sel,
  output logic [7:0] probe_data
);
  localparam int SEC_W = $clog2(NUM_SEC);

  logic        sck_rise, sck_fall, cs_act, cs_release, mosi_s;
  logic [7:0]  opcode;
  logic [23:0] addr;
  logic [5:0]  nbits;
  logic        busy, wel, erase_go;
  logic [SEC_W-1:0] erase_sec;
  blk_e        erase_blk;
  logic [7:0]  status;

  assign status = {6'd0, wel, busy};

  sfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
    .cs_release(cs_release), .mosi_s(mosi_s)
  );

  sfe_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_act(cs_act), .mosi_s(mosi_s), .status(status),
    .opcode(opcode), .addr(addr), .nbits(nbits), .miso(miso)
  );

  sfe_seq #(.NUM_SEC(NUM_SEC), .ERASE_CYCLES(ERASE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_release(cs_release), .opcode(opcode),
    .addr(addr), .nbits(nbits), .busy(busy), .wel(wel), .erase_go(erase_go),
    .erase_sec(erase_sec), .erase_blk(erase_blk)
  );

  sfe_array #(.NUM_SEC(NUM_SEC)) u_array (
    .clk(clk), .rst_n(rst_n), .erase_go(erase_go), .erase_sec(erase_sec),
    .erase_blk(erase_blk), .probe_sel(probe_sel), .probe_data(probe_data)
  );
endmodule

// File: tb/test_sflash_erase_ctrl.sv
module test_sflash_erase_ctrl;
  localparam int NSEC = 64;
  localparam int ECYC = 1000;
  localparam int H    = 4;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [5:0] probe_sel = '0;
  wire        miso;
  wire  [7:0] probe_data;

  always #10 clk = ~clk;

  sflash_erase_ctrl #(.NUM_SEC(NSEC), .ERASE_CYCLES(ECYC)) i_sflash_erase_ctrl (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .probe_sel(probe_sel), .probe_data(probe_data)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural reference model
  int mem_m [NSEC];
  int pend = 0;
  bit wel_m = 0;
  int act_cnt = 0;
  logic [7:0]  act_op, er_op;
  int          act_bits;
  logic [23:0] act_addr, er_addr;
  logic [7:0]  t_op;
  logic [23:0] t_addr;
  int          t_bits;

  function automatic bit op_is_erase(logic [7:0] op);
    return op == 8'h20 || op == 8'h52 || op == 8'hD8;
  endfunction

  task automatic model_erase(logic [7:0] op, logic [23:0] a);
    int span, first;
    span  = (op == 8'h20) ? 1 : (op == 8'h52) ? 8 : 16;
    first = ((int'(a) / 4096) / span) * span;
    for (int j = 0; j < span; j++) mem_m[(first + j) % NSEC] = 255;
  endtask

  always @(posedge clk) begin
    bit busy_b;
    if (!rst_n) begin
      for (int i = 0; i < NSEC; i++) mem_m[i] = (i ^ 'h5A) & 'hFF;
      pend = 0; wel_m = 0; act_cnt = 0;
    end else begin
      busy_b = pend > 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) model_erase(er_op, er_addr);
      end
      if (act_cnt > 0) begin
        act_cnt--;
        if (act_cnt == 0 && !busy_b) begin
          if (act_op == 8'h06 && act_bits >= 8) wel_m = 1;
          else if (op_is_erase(act_op) && act_bits == 32 && wel_m) begin
            wel_m = 0; pend = ECYC; er_op = act_op; er_addr = act_addr;
          end
        end
      end
    end
  end

  // array compared against the model on every clock (R1, R5, R9)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (probe_data !== 8'(mem_m[probe_sel])) begin
        errors++;
        $display("FAIL R1/R5/R9 sector %0d: got %02h expected %02h",
                 probe_sel, probe_data, 8'(mem_m[probe_sel]));
      end
      probe_sel = probe_sel + 6'd1;
    end
  end

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0; t_bits = 0; t_op = '0; t_addr = '0;
    tick(H);
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      tick(H);
      r[i] = miso;
      sck = 1'b1;
      if (t_bits < 8) t_op = {t_op[6:0], b[i]};
      else if (t_bits < 32) t_addr = {t_addr[22:0], b[i]};
      if (t_bits < 32) t_bits++;
      tick(H);
      sck = 1'b0;
    end
  endtask

  task automatic release_cs();
    cs_n = 1'b1;
    act_op = t_op; act_bits = t_bits; act_addr = t_addr; act_cnt = 3;
    tick(8);
  endtask

  task automatic send_cmd(logic [7:0] op, int naddr, logic [23:0] a, int ntrail);
    logic [7:0] r;
    cs_begin();
    xbyte(op, r);
    for (int k = 0; k < naddr; k++) xbyte(a[23 - 8*k -: 8], r);
    for (int k = 0; k < ntrail; k++) xbyte(8'hFF, r);
    tick(H);
    release_cs();
  endtask

  task automatic read_status(string req, int nbytes);
    logic [7:0] r, exp;
    exp = {6'd0, wel_m, pend > 0};
    cs_begin();
    xbyte(8'h05, r);
    for (int k = 0; k < nbytes; k++) begin
      xbyte(8'h00, r);
      chk(req, r, exp);
    end
    tick(H);
    release_cs();
  endtask

  task automatic wait_idle();
    while (pend > 0) tick(1);
    tick(10);
  endtask

  // Write Enable whose release is processed when the model's count is at p
  task automatic wren_at(int p);
    logic [7:0] r;
    cs_begin();
    xbyte(8'h06, r);
    while (pend != p) tick(1);
    release_cs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R1 miso idle", {7'd0, miso}, 8'h00);
    read_status("R1 status after reset", 1);

    // R6: erase without latch
    send_cmd(8'h20, 3, 24'h001234, 0);
    read_status("R6 erase without latch", 1);

    // R2: write enable
    send_cmd(8'h06, 0, 24'h0, 0);
    read_status("R2 latch set", 1);

    // R11: unknown opcode
    send_cmd(8'hAB, 3, 24'h000000, 1);
    read_status("R11 unknown opcode", 1);

    // R7: short erase is dropped, latch kept
    send_cmd(8'h20, 2, 24'h003000, 0);
    read_status("R7 short command", 1);

    // R4: 4 KB erase at sector 3; R3 two status bytes while busy
    send_cmd(8'h20, 3, 24'h003ABC, 0);
    read_status("R3/R4 busy, latch cleared", 2);
    // R10: commands while busy
    send_cmd(8'h06, 0, 24'h0, 0);
    send_cmd(8'h52, 3, 24'h010000, 0);
    read_status("R10 ignored while busy", 1);
    wait_idle();
    read_status("R9 busy cleared", 1);

    // R5, R8: 32 KB erase with trailing bytes (sectors 32..39)
    send_cmd(8'h06, 0, 24'h0, 0);
    send_cmd(8'h52, 3, 24'h0A1234, 2);
    wait_idle();
    read_status("R8 trailing bytes", 1);

    // R5: 64 KB erase (sectors 16..31)
    send_cmd(8'h06, 0, 24'h0, 0);
    send_cmd(8'hD8, 3, 24'h05FFFF, 0);
    wait_idle();
    read_status("R5 64K done", 1);

    // R10: release processed in the completion clock is ignored
    send_cmd(8'h06, 0, 24'h0, 0);
    send_cmd(8'h20, 3, 24'h000000, 0);
    wren_at(3);
    wait_idle();
    read_status("R10 same-cycle release", 1);

    // R2: release one clock after completion is accepted
    send_cmd(8'h06, 0, 24'h0, 0);
    send_cmd(8'h20, 3, 24'h001000, 0);
    wren_at(2);
    wait_idle();
    read_status("R2 release after completion", 1);

    tick(NSEC + 4);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule